// File: doc/BRIEF.md
# Bidirectional Eight-Phase Index Sequencer

This block is the digital control core of a fractional clock divider that works by walking through eight copies of a clock spaced 45 degrees apart. Each pulse on `next_i` advances a 3-bit divider chain whose bits toggle at one half, one quarter and one eighth of the pulse rate. A per-bit inversion stage, followed by one fixed table, turns that word into the number of the phase to select, from 1 to 8. With the inversion off, the selection walks downward through the phases, which removes an eighth of an input period per pulse and shortens the output period. With the inversion on, the same chain walks upward, which adds an eighth per pulse and lengthens the period.

The sequencer also measures itself. It splits time into frames of 16 clock cycles, counts the pulses in each frame and reports the effective division ratio in eighths: 128 minus the count going backward, 128 plus the count going forward. The direction input is sampled only when a frame begins, so a frame never mixes the two step directions. The starting phase comes from an input that is sampled on the first clock edge after reset.

Top module: `octphase_seq`

## Requirements
- R1: While reset is asserted, ctrl_o is 000, phase_idx_o is 8, cur_fwd_o, frame_done_o, frame_steps_o and frame_ratio_o are all 0.
- R2: On the first clock edge after reset release, the block takes its direction from fwd_i and its starting phase from init_phase_i (code 0 means phase 8, code k means phase k); ctrl_o becomes init_phase_i when fwd_i is 0 and its bitwise inverse when fwd_i is 1, and a pulse on next_i at that edge is ignored.
- R3: After that edge, every clock edge with next_i high lowers ctrl_o by one modulo 8, so ctrl_o[0], ctrl_o[1] and ctrl_o[2] toggle at 1/2, 1/4 and 1/8 of the pulse rate; with next_i low, ctrl_o holds.
- R4: With cur_fwd_o = 0, phase_idx_o follows ctrl_o as 111→7, 110→6, 101→5, 100→4, 011→3, 010→2, 001→1, 000→8.
- R5: With cur_fwd_o = 1, phase_idx_o follows ctrl_o as 111→8, 110→1, 101→2, 100→3, 011→4, 010→5, 001→6, 000→7.
- R6: Within a frame, each pulse moves phase_idx_o one step down (1 wraps to 8) when cur_fwd_o is 0 and one step up (8 wraps to 1) when cur_fwd_o is 1.
- R7: Frames are 16 clock edges long, counted from the edge after the starting edge of R2; frame_done_o is high for exactly the one cycle after the last edge of each frame.
- R8: While frame_done_o is high, frame_steps_o equals the number of edges in the finished frame at which next_i was high (0 to 16).
- R9: While frame_done_o is high, frame_ratio_o equals 128 − frame_steps_o if the finished frame ran backward and 128 + frame_steps_o if it ran forward (the ratio in units of 1/8, so 15 backward pulses give 113 = 14.125 × 8).
- R10: fwd_i is sampled only on the last edge of each frame (and on the starting edge); changes at other edges have no effect on cur_fwd_o or phase_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| next_i | input | 1 | Step request, one per cycle at most |
| fwd_i | input | 1 | Requested direction: 1 forward (longer period), 0 backward |
| init_phase_i | input | 3 | Starting phase code, 0 meaning phase 8 |
| ctrl_o | output | 3 | Divider chain word, bit 2 the slowest |
| phase_idx_o | output | 4 | Selected phase, 1 to 8 |
| cur_fwd_o | output | 1 | Direction in force for the current frame |
| frame_done_o | output | 1 | One-cycle strobe after each 16-cycle frame |
| frame_steps_o | output | 5 | Pulses counted in the finished frame |
| frame_ratio_o | output | 8 | Effective division ratio of the finished frame, times 8 |

## Verification
The bench aims at the wrap points of both tables: the step from phase 1 to 8 going backward and from 8 to 1 going forward, where a design with the wrong counting sense or a missing inversion would walk the phases in reverse or jump by several steps. It toggles fwd_i at random inside every frame, so a design that samples direction anywhere but at the frame boundary shows a mixed-direction frame and a wrong ratio. Frames with 0, 7, 15 and 16 pulses, including a pulse on the very last edge, expose an off-by-one in the frame length or a last pulse lost from the count, and a pulse on the starting edge catches a design that steps while it seeds.

// File: rtl/octphase_pkg.sv
`timescale 1ns/1ps
package octphase_pkg;

  localparam int unsigned DEF_CTRL_W    = 3;
  localparam int unsigned DEF_FRAME_LEN = 16;

  typedef enum logic {
    DIR_BWD = 1'b0,
    DIR_FWD = 1'b1
  } step_dir_e;

  // Width needed for FRAME_LEN*PHASES plus up to FRAME_LEN extra steps.
  function automatic int unsigned ratio_width(int unsigned frame_len, int unsigned phases);
    return $clog2(frame_len * phases + frame_len + 1);
  endfunction

endpackage

// File: rtl/octphase_divider.sv
`timescale 1ns/1ps
// Borrow-chain down counter: each stage toggles when every lower stage is 0,
// so stage b toggles at 1/2^(b+1) of the step rate.
module octphase_divider #(
  parameter int unsigned CTRL_W = octphase_pkg::DEF_CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [CTRL_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [CTRL_W-1:0] ctrl_o
);

  logic [CTRL_W-1:0] cnt_q;
  logic [CTRL_W-1:0] cnt_d;
  logic [CTRL_W-1:0] borrow;
  logic              cnt_en;

  always_comb begin
    borrow[0] = step_i;
    for (int b = 1; b < CTRL_W; b++) begin
      borrow[b] = borrow[b-1] & ~cnt_q[b-1];
    end
  end

  for (genvar b = 0; b < CTRL_W; b++) begin : g_stage
    always_comb begin
      if (load_en_i) begin
        cnt_d[b] = load_val_i[b];
      end else begin
        cnt_d[b] = cnt_q[b] ^ borrow[b];
      end
    end
  end

  assign cnt_en = load_en_i | step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ctrl_o = cnt_q;

endmodule

// File: rtl/octphase_phase_map.sv
`timescale 1ns/1ps
// Inversion stage followed by one fixed word-to-phase table. The all-zero
// selector names the highest phase; every other selector names itself.
module octphase_phase_map #(
  parameter  int unsigned CTRL_W = octphase_pkg::DEF_CTRL_W,
  localparam int unsigned IDX_W  = CTRL_W + 1
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              fwd_i,
  output logic [IDX_W-1:0]  phase_o
);

  localparam logic [IDX_W-1:0] PHASE_TOP = {1'b1, {CTRL_W{1'b0}}};

  logic [CTRL_W-1:0] sel;

  for (genvar b = 0; b < CTRL_W; b++) begin : g_inv
    assign sel[b] = ctrl_i[b] ^ fwd_i;
  end

  always_comb begin
    if (sel == '0) begin
      phase_o = PHASE_TOP;
    end else begin
      phase_o = {1'b0, sel};
    end
  end

endmodule

// File: rtl/octphase_frame_meter.sv
`timescale 1ns/1ps
// Frame timer, pulse tally, direction latch and ratio report.
module octphase_frame_meter #(
  parameter  int unsigned FRAME_LEN = octphase_pkg::DEF_FRAME_LEN,
  parameter  int unsigned PHASES    = 8,
  localparam int unsigned FRM_W     = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
  localparam int unsigned STEP_W    = $clog2(FRAME_LEN + 1),
  localparam int unsigned RAT_W     = octphase_pkg::ratio_width(FRAME_LEN, PHASES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              pulse_i,
  input  logic              fwd_i,
  output logic              cur_fwd_o,
  output logic              last_o,
  output logic              done_o,
  output logic [STEP_W-1:0] steps_o,
  output logic [RAT_W-1:0]  ratio_o
);

  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(FRAME_LEN - 1);
  localparam logic [RAT_W-1:0] RAT_BASE = RAT_W'(FRAME_LEN * PHASES);

  logic [FRM_W-1:0]  frm_q,   frm_d;
  logic [STEP_W-1:0] acc_q,   acc_d;
  logic              dir_q,   dir_d;
  logic              done_q,  done_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [RAT_W-1:0]  ratio_q, ratio_d;
  logic [STEP_W-1:0] acc_sum;
  logic              meter_en;

  assign last_o   = (frm_q == FRM_LAST);
  assign acc_sum  = acc_q + STEP_W'(pulse_i);
  assign meter_en = start_i | run_i;

  always_comb begin
    frm_d   = frm_q;
    acc_d   = acc_q;
    dir_d   = dir_q;
    done_d  = 1'b0;
    steps_d = steps_q;
    ratio_d = ratio_q;
    if (start_i) begin
      frm_d = '0;
      acc_d = '0;
      dir_d = fwd_i;
    end else if (run_i) begin
      if (last_o) begin
        frm_d   = '0;
        acc_d   = '0;
        dir_d   = fwd_i;
        done_d  = 1'b1;
        steps_d = acc_sum;
        if (dir_q == octphase_pkg::DIR_FWD) begin
          ratio_d = RAT_BASE + RAT_W'(acc_sum);
        end else begin
          ratio_d = RAT_BASE - RAT_W'(acc_sum);
        end
      end else begin
        frm_d = frm_q + 1'b1;
        acc_d = acc_sum;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q   <= '0;
      acc_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      steps_q <= '0;
      ratio_q <= '0;
    end else if (meter_en) begin
      frm_q   <= frm_d;
      acc_q   <= acc_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
      steps_q <= steps_d;
      ratio_q <= ratio_d;
    end
  end

  assign cur_fwd_o = dir_q;
  assign done_o    = done_q;
  assign steps_o   = steps_q;
  assign ratio_o   = ratio_q;

endmodule

// File: rtl/octphase_seq.sv
`timescale 1ns/1ps
module octphase_seq #(
  parameter  int unsigned CTRL_W    = octphase_pkg::DEF_CTRL_W,
  parameter  int unsigned FRAME_LEN = octphase_pkg::DEF_FRAME_LEN,
  localparam int unsigned PHASES    = 1 << CTRL_W,
  localparam int unsigned IDX_W     = CTRL_W + 1,
  localparam int unsigned STEP_W    = $clog2(FRAME_LEN + 1),
  localparam int unsigned RAT_W     = octphase_pkg::ratio_width(FRAME_LEN, PHASES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              next_i,
  input  logic              fwd_i,
  input  logic [CTRL_W-1:0] init_phase_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [IDX_W-1:0]  phase_idx_o,
  output logic              cur_fwd_o,
  output logic              frame_done_o,
  output logic [STEP_W-1:0] frame_steps_o,
  output logic [RAT_W-1:0]  frame_ratio_o
);

  logic              started_q;
  logic              started_d;
  logic              seed_en;
  logic              step_en;
  logic [CTRL_W-1:0] seed_word;
  logic              frame_last;

  // Seeding happens once, on the first edge after reset release.
  assign started_d = 1'b1;
  assign seed_en   = ~started_q;
  assign step_en   = started_q & next_i;
  // Seed through the same inversion the phase table applies, so the
  // requested phase appears for either direction.
  assign seed_word = init_phase_i ^ {CTRL_W{fwd_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
    end else if (seed_en) begin
      started_q <= started_d;
    end
  end

  octphase_divider #(
    .CTRL_W (CTRL_W)
  ) u_divider (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (seed_en),
    .load_val_i (seed_word),
    .step_i     (step_en),
    .ctrl_o     (ctrl_o)
  );

  octphase_frame_meter #(
    .FRAME_LEN (FRAME_LEN),
    .PHASES    (PHASES)
  ) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (seed_en),
    .run_i     (started_q),
    .pulse_i   (next_i),
    .fwd_i     (fwd_i),
    .cur_fwd_o (cur_fwd_o),
    .last_o    (frame_last),
    .done_o    (frame_done_o),
    .steps_o   (frame_steps_o),
    .ratio_o   (frame_ratio_o)
  );

  octphase_phase_map #(
    .CTRL_W (CTRL_W)
  ) u_map (
    .ctrl_i  (ctrl_o),
    .fwd_i   (cur_fwd_o),
    .phase_o (phase_idx_o)
  );

endmodule

// File: rtl/octphase_seq_chk.sv
`timescale 1ns/1ps
module octphase_seq_chk #(
  parameter  int unsigned CTRL_W    = 3,
  parameter  int unsigned FRAME_LEN = 16,
  localparam int unsigned IDX_W     = CTRL_W + 1,
  localparam int unsigned STEP_W    = $clog2(FRAME_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              next_i,
  input logic              started_q,
  input logic              frame_last,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [IDX_W-1:0]  phase_idx_o,
  input logic              cur_fwd_o,
  input logic              frame_done_o,
  input logic [STEP_W-1:0] frame_steps_o
);

  localparam logic [IDX_W-1:0]  P_TOP = IDX_W'(1 << CTRL_W);
  localparam logic [IDX_W-1:0]  P_ONE = IDX_W'(1);
  localparam logic [STEP_W-1:0] S_MAX = STEP_W'(FRAME_LEN);

  // R3: a pulse lowers the control word by one
  a_r3_ctrl_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && next_i) |=> (ctrl_o == CTRL_W'($past(ctrl_o) - 1'b1)));

  // R3: no pulse, no change
  a_r3_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !next_i) |=> $stable(ctrl_o));

  // R4 / R5: index always names a real phase
  a_r4_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (phase_idx_o >= P_ONE && phase_idx_o <= P_TOP));

  // R6: backward walk goes down with wrap
  a_r6_bwd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && next_i && !frame_last && !cur_fwd_o) |=>
      (phase_idx_o == (($past(phase_idx_o) == P_ONE) ? P_TOP : IDX_W'($past(phase_idx_o) - 1'b1))));

  // R6: forward walk goes up with wrap
  a_r6_fwd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && next_i && !frame_last && cur_fwd_o) |=>
      (phase_idx_o == (($past(phase_idx_o) == P_TOP) ? P_ONE : IDX_W'($past(phase_idx_o) + 1'b1))));

  // R7: the frame strobe follows the last edge and lasts one cycle
  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && frame_last) |=> frame_done_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R8: a frame cannot hold more pulses than cycles
  a_r8_steps_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (frame_steps_o <= S_MAX));

  // R10: direction only moves at the frame boundary
  a_r10_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !frame_last) |=> $stable(cur_fwd_o));

endmodule

bind octphase_seq octphase_seq_chk #(
  .CTRL_W    (CTRL_W),
  .FRAME_LEN (FRAME_LEN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .next_i        (next_i),
  .started_q     (started_q),
  .frame_last    (frame_last),
  .ctrl_o        (ctrl_o),
  .phase_idx_o   (phase_idx_o),
  .cur_fwd_o     (cur_fwd_o),
  .frame_done_o  (frame_done_o),
  .frame_steps_o (frame_steps_o)
);

// File: tb/octphase_seq_tb_top.sv
`timescale 1ns/1ps
module octphase_seq_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       next_i = 1'b0;
  logic       fwd_i = 1'b0;
  logic [2:0] init_phase_i = 3'd0;
  logic [2:0] ctrl_o;
  logic [3:0] phase_idx_o;
  logic       cur_fwd_o;
  logic       frame_done_o;
  logic [4:0] frame_steps_o;
  logic [7:0] frame_ratio_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model state
  bit m_started;
  int m_c, m_dir, m_frm, m_acc, m_done, m_steps, m_ratio;

  always #2.5 clk_i = ~clk_i;

  octphase_seq dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .next_i        (next_i),
    .fwd_i         (fwd_i),
    .init_phase_i  (init_phase_i),
    .ctrl_o        (ctrl_o),
    .phase_idx_o   (phase_idx_o),
    .cur_fwd_o     (cur_fwd_o),
    .frame_done_o  (frame_done_o),
    .frame_steps_o (frame_steps_o),
    .frame_ratio_o (frame_ratio_o)
  );

  // R4 table
  function automatic int phase_bwd(int c);
    case (c)
      7: return 7; 6: return 6; 5: return 5; 4: return 4;
      3: return 3; 2: return 2; 1: return 1; default: return 8;
    endcase
  endfunction

  // R5 table
  function automatic int phase_fwd(int c);
    case (c)
      7: return 8; 6: return 1; 5: return 2; 4: return 3;
      3: return 4; 2: return 5; 1: return 6; default: return 7;
    endcase
  endfunction

  function automatic int exp_phase(int c, int dir);
    return (dir != 0) ? phase_fwd(c) : phase_bwd(c);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit nx, input bit fw, input bit release_rst);
    int  prev_phase;
    bit  boundary;
    int  exp_walk;
    @(negedge clk_i);
    if (release_rst) rst_ni = 1'b1;
    next_i = nx;
    fwd_i  = fw;
    prev_phase = phase_idx_o;
    boundary   = (m_frm == 15);
    @(posedge clk_i);
    #1;
    if (!m_started) begin
      m_started = 1'b1;
      m_c   = (fw != 0) ? (7 - int'(init_phase_i)) : int'(init_phase_i);
      m_dir = fw;
      m_frm = 0;
      m_acc = 0;
      m_done = 0;
    end else begin
      if (nx) m_c = (m_c + 7) % 8;
      if (m_frm == 15) begin
        m_steps = m_acc + nx;
        m_ratio = (m_dir != 0) ? 128 + m_steps : 128 - m_steps;
        m_done  = 1;
        m_acc   = 0;
        m_dir   = fw;
        m_frm   = 0;
      end else begin
        m_acc  = m_acc + nx;
        m_frm  = m_frm + 1;
        m_done = 0;
      end
      // R6: step-by-step walk inside a frame
      if (nx && !boundary) begin
        if (m_dir != 0) exp_walk = (prev_phase == 8) ? 1 : prev_phase + 1;
        else            exp_walk = (prev_phase == 1) ? 8 : prev_phase - 1;
        check("R6 phase walk", phase_idx_o, exp_walk);
      end
    end
    check("R3 ctrl word", ctrl_o, m_c);
    check((m_dir != 0) ? "R5 forward phase" : "R4 backward phase",
          phase_idx_o, exp_phase(m_c, m_dir));
    check("R7 frame_done", frame_done_o, m_done);
    check("R10 latched direction", cur_fwd_o, m_dir);
    if (m_done != 0) begin
      check("R8 frame steps", frame_steps_o, m_steps);
      check("R9 frame ratio", frame_ratio_o, m_ratio);
    end
  endtask

  task automatic do_reset(input logic [2:0] init, input bit fw, input bit nx_on_load);
    int exp_p;
    @(negedge clk_i);
    rst_ni = 1'b0;
    next_i = 1'b0;
    init_phase_i = init;
    fwd_i = fw;
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 reset ctrl", ctrl_o, 0);
    check("R1 reset phase", phase_idx_o, 8);
    check("R1 reset direction", cur_fwd_o, 0);
    check("R1 reset frame_done", frame_done_o, 0);
    check("R1 reset steps", frame_steps_o, 0);
    check("R1 reset ratio", frame_ratio_o, 0);
    m_started = 1'b0;
    m_c = 0; m_dir = 0; m_frm = 0; m_acc = 0; m_done = 0; m_steps = 0; m_ratio = 0;
    tick(nx_on_load, fw, 1'b1);
    exp_p = (init == 3'd0) ? 8 : int'(init);
    check("R2 starting phase", phase_idx_o, exp_p);
    check("R2 seeded ctrl ignores pulse", ctrl_o, fw ? (7 - int'(init)) : int'(init));
  endtask

  // one frame with n pulses; fwd_i wanders inside the frame (R10) and
  // carries dir_next on the final edge
  task automatic run_frame(input int n, input bit dir_next);
    int remaining = n;
    for (int k = 0; k < 16; k++) begin
      bit nx;
      bit fw;
      int left = 16 - k;
      nx = (remaining >= left) || ((remaining > 0) && ($urandom_range(0, 1) == 1));
      if (nx) remaining--;
      fw = (k == 15) ? dir_next : bit'($urandom_range(0, 1));
      tick(nx, fw, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h0C7A_5EED));
    // R2: start at phase One going backward, pulse on the seeding edge
    do_reset(3'd1, 1'b0, 1'b1);
    run_frame(15, 1'b0);   // R9: 113
    check("R9 backward 15 pulses", frame_ratio_o, 113);
    run_frame(0, 1'b1);    // R9: 128
    check("R9 no pulses", frame_ratio_o, 128);
    run_frame(7, 1'b1);    // R9: 135
    check("R9 forward 7 pulses", frame_ratio_o, 135);
    run_frame(15, 1'b1);   // R9: 143
    check("R9 forward 15 pulses", frame_ratio_o, 143);
    run_frame(16, 1'b0);   // R8: full frame forward
    check("R8 pulse every cycle", frame_steps_o, 16);
    run_frame(16, 1'b1);
    check("R9 backward 16 pulses", frame_ratio_o, 112);
    // R2: start at phase Eight going forward
    do_reset(3'd0, 1'b1, 1'b0);
    for (int f = 0; f < 30; f++) begin
      run_frame($urandom_range(0, 16), bit'($urandom_range(0, 1)));
    end
    do_reset(3'd5, 1'b0, 1'b0);
    for (int f = 0; f < 10; f++) begin
      run_frame($urandom_range(0, 16), bit'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule